// File: doc/BRIEF.md
# Page-Aware Serial Flash Program Engine

This engine writes a stream of bytes into a serial NOR flash, starting at a byte address it is given. A request supplies a start address and a byte count. The bytes then arrive on a valid/ready stream, and the engine turns them into a sequence of commands on a flash command port. A command sequencer or a flash model sits behind that port and acknowledges each command.

The engine handles the whole write protocol by itself. Before every program burst it sends a write-enable. It picks the program opcode from the address range of the request. It streams bytes while chip select stays held. At every 256-byte page boundary, and after the final byte, it releases chip select and polls the flash status until the write-in-progress bit clears.

When a request ends, the engine reports how many bytes it programmed. It also flags two errors: a request that goes past the end of the device, and a status poll that runs too long.

Top module: `flash_prog_engine`

## Requirements
- R1: `req_ready` is high only while the engine is idle. A request with `req_addr + req_len > DEV_BYTES` raises `done` on the cycle after it is accepted, with `err_range`=1 and `done_count`=0, and issues no command. A request ending exactly at `DEV_BYTES` is accepted.
- R2: A request with `req_len`=0 raises `done` on the cycle after it is accepted, with no error, `done_count`=0 and no command.
- R3: Every program burst, the first one included, is preceded by a command of kind 0 (opcode only) with opcode 0x06. After that command completes, the engine waits for a byte and has no command pending.
- R4: When `req_addr + req_len <= 2^24`, every program command of the request carries opcode 0x02 with `cmd_wide`=0. Otherwise every program command carries opcode 0x12 with `cmd_wide`=1.
- R5: The first byte of each burst goes out in a command of kind 2 (program), together with its byte address in `cmd_addr` and the byte in `cmd_data`. Each later byte of the same burst goes out alone in a command of kind 3 (data byte), in stream order.
- R6: A burst ends after the byte whose following address is a multiple of 256. The engine then issues a command of kind 4 (chip-select release), followed directly by status reads.
- R7: A status read is a command of kind 1 with opcode 0x05. While bit 0 of `cmd_rdata` is 1 the read is repeated. Bits 7:1 have no effect. When bit 0 is 0, the next burst starts with R3.
- R8: After the last byte of the request, the engine issues a release, then polls as in R7, then raises `done` with `done_count` equal to `req_len` and no error. A request whose last byte ends a page gets only one release and one poll.
- R9: If a poll phase lasts `POLL_LIMIT` cycles without reading bit 0 as 0, the engine abandons it. It then raises `done` with `err_timeout`=1, and `done_count` gives the number of bytes already sent.
- R10: `din_ready` is high only while the engine waits for the next byte. It is low during write-enable, program, data, release and poll commands, and it is never high together with `cmd_valid`.
- R11: Once `cmd_valid` is raised, the command fields stay unchanged until the cycle in which `cmd_done` is sampled high. The only exception is a poll abandoned under R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Engine idle, accepts a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| din_valid | input | 1 | Byte stream valid |
| din_ready | output | 1 | Byte stream ready |
| din_data | input | 8 | Byte to program |
| cmd_valid | output | 1 | Command pending |
| cmd_kind | output | 3 | 0 opcode, 1 status read, 2 program, 3 data byte, 4 release |
| cmd_op | output | 8 | Opcode for kinds 0, 1, 2 |
| cmd_addr | output | ADDR_W | Byte address for kind 2 |
| cmd_wide | output | 1 | Kind 2 uses a 4-byte address |
| cmd_data | output | 8 | Data byte for kinds 2 and 3 |
| cmd_done | input | 1 | Command finished (high while `cmd_valid` is high) |
| cmd_rdata | input | 8 | Status byte returned with a finished status read |
| done | output | 1 | One-cycle request completion |
| done_count | output | LEN_W | Bytes programmed by the last request |
| err_range | output | 1 | Last request went past the device end |
| err_timeout | output | 1 | Last request hit the poll limit |

## Verification
The main function is exercised with several request shapes:
- A short write inside one page shows that no split happens.
- Writes that start just below a boundary, and a write covering several pages, check where the split lands and how the stream resumes after it.
- A write that ends exactly on a page end separates the final release from a boundary release.

The bench also probes both sides of the 16 MiB window and the device end, so the opcode choice and the range check are each tested at their edges. Running the byte stream with gaps and without gaps shows that the command order does not depend on source timing. A flash that never clears its busy bit drives the poll timeout.

// File: rtl/flash_prog_engine.sv
module flash_prog_engine #(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 16,
  parameter longint unsigned DEV_BYTES = 64'h0200_0000,
  parameter longint unsigned WINDOW_BYTES = 64'h0100_0000,
  parameter int PAGE_BYTES = 256,
  parameter int POLL_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [7:0]        din_data,
  output logic              cmd_valid,
  output logic [2:0]        cmd_kind,
  output logic [7:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_wide,
  output logic [7:0]        cmd_data,
  input  logic              cmd_done,
  input  logic [7:0]        cmd_rdata,
  output logic              done,
  output logic [LEN_W-1:0]  done_count,
  output logic              err_range,
  output logic              err_timeout
);

  localparam int EXT_W  = ADDR_W + 1;
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int CNT_W  = $clog2(POLL_LIMIT + 1);
  localparam logic [EXT_W-1:0] DEV_LIM = EXT_W'(DEV_BYTES);
  localparam logic [EXT_W-1:0] WIN_LIM = EXT_W'(WINDOW_BYTES);

  localparam logic [2:0] K_OP = 3'd0, K_RDSR = 3'd1, K_PROG = 3'd2, K_DATA = 3'd3, K_REL = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_WREN, S_GETB, S_SEND, S_REL, S_POLL, S_DONE} st_t;

  st_t               st;
  logic [ADDR_W-1:0] cur;
  logic [LEN_W-1:0]  left, sent;
  logic              wide, first;
  logic [7:0]        byte_q;
  logic [CNT_W-1:0]  poll_cnt;

  logic [EXT_W-1:0]  req_end;
  logic [ADDR_W-1:0] cur_nxt;
  logic              wip, unused_status;

  assign req_end       = {1'b0, req_addr} + EXT_W'(req_len);
  assign cur_nxt       = cur + 1'b1;
  assign wip           = cmd_rdata[0];
  assign unused_status = ^cmd_rdata[7:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur <= '0;
      left <= '0;
      sent <= '0;
      wide <= 1'b0;
      first <= 1'b0;
      byte_q <= '0;
      poll_cnt <= '0;
      err_range <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          cur <= req_addr;
          left <= req_len;
          sent <= '0;
          err_range <= 1'b0;
          err_timeout <= 1'b0;
          wide <= req_end > WIN_LIM;
          first <= 1'b1;
          if (req_len == '0) st <= S_DONE;
          else if (req_end > DEV_LIM) begin
            err_range <= 1'b1;
            st <= S_DONE;
          end else st <= S_WREN;
        end
        S_WREN: if (cmd_done) st <= S_GETB;
        S_GETB: if (din_valid) begin
          byte_q <= din_data;
          st <= S_SEND;
        end
        S_SEND: if (cmd_done) begin
          cur <= cur_nxt;
          left <= left - 1'b1;
          sent <= sent + 1'b1;
          first <= 1'b0;
          if (left == LEN_W'(1) || cur_nxt[PAGE_W-1:0] == '0) st <= S_REL;
          else st <= S_GETB;
        end
        S_REL: if (cmd_done) begin
          poll_cnt <= '0;
          st <= S_POLL;
        end
        S_POLL: begin
          poll_cnt <= poll_cnt + 1'b1;
          if (cmd_done && !wip) begin
            first <= 1'b1;
            st <= (left == '0) ? S_DONE : S_WREN;
          end else if (poll_cnt == CNT_W'(POLL_LIMIT - 1)) begin
            err_timeout <= 1'b1;
            st <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = st == S_IDLE;
  assign din_ready  = st == S_GETB;
  assign done       = st == S_DONE;
  assign done_count = sent;
  assign cmd_valid  = st inside {S_WREN, S_SEND, S_REL, S_POLL};
  assign cmd_addr   = cur;
  assign cmd_wide   = wide;
  assign cmd_data   = byte_q;

  always_comb begin
    cmd_kind = K_OP;
    cmd_op   = 8'h00;
    case (st)
      S_WREN: cmd_op = 8'h06;
      S_POLL: begin cmd_kind = K_RDSR; cmd_op = 8'h05; end
      S_SEND: begin
        cmd_kind = first ? K_PROG : K_DATA;
        if (first) cmd_op = wide ? 8'h12 : 8'h02;
      end
      S_REL:  cmd_kind = K_REL;
      default: ;
    endcase
  end

endmodule

// File: rtl/flash_prog_engine_sva.sv
module flash_prog_engine_sva #(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LEN_W-1:0]  req_len,
  input logic              din_ready,
  input logic              cmd_valid,
  input logic [2:0]        cmd_kind,
  input logic [7:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [7:0]        cmd_data,
  input logic              cmd_done,
  input logic [7:0]        cmd_rdata,
  input logic              done,
  input logic [LEN_W-1:0]  done_count,
  input logic              err_range,
  input logic              err_timeout
);

  a_r1_range_no_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    done && err_range |-> done_count == '0 && !err_timeout);

  a_r2_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_len == '0 |=> done && !err_range && !err_timeout && done_count == '0);

  a_r3_wren_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_done && cmd_kind == 3'd0 |=> din_ready && !cmd_valid);

  a_r4_prog_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind == 3'd2 |-> cmd_op == 8'h02 || cmd_op == 8'h12);

  a_r6_release_then_poll: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_done && cmd_kind == 3'd4 |=> cmd_valid && cmd_kind == 3'd1 && cmd_op == 8'h05);

  a_r7_busy_repoll: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_done && cmd_kind == 3'd1 && cmd_rdata[0] |=> (cmd_valid && cmd_kind == 3'd1) || done);

  a_r10_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> !cmd_valid);

  a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done && cmd_kind != 3'd1 |=>
      cmd_valid && $stable(cmd_kind) && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_data));

endmodule

bind flash_prog_engine flash_prog_engine_sva #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_len(req_len),
  .din_ready(din_ready), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_op(cmd_op),
  .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
  .done(done), .done_count(done_count), .err_range(err_range), .err_timeout(err_timeout)
);

// File: tb/sim_flash_prog_engine.sv
`timescale 1ns/1ps
module sim_flash_prog_engine;

  localparam int POLL_LIM = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_ready, din_valid, din_ready;
  logic [31:0] req_addr, cmd_addr;
  logic [15:0] req_len, done_count;
  logic [7:0] din_data, cmd_op, cmd_data, cmd_rdata;
  logic [2:0] cmd_kind;
  logic cmd_valid, cmd_wide, cmd_done, done, err_range, err_timeout;

  flash_prog_engine #(.POLL_LIMIT(POLL_LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .din_valid(din_valid), .din_ready(din_ready),
    .din_data(din_data), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wide(cmd_wide), .cmd_data(cmd_data), .cmd_done(cmd_done),
    .cmd_rdata(cmd_rdata), .done(done), .done_count(done_count), .err_range(err_range),
    .err_timeout(err_timeout));

  logic [51:0] expq[$];
  logic [7:0]  bq[$];
  int compared = 0, mismatched = 0;
  int busy_n = 0, busy_left = 0;
  bit allow_polls = 0, gap = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string ktag(logic [2:0] k);
    case (k)
      3'd0: return "R3";
      3'd1: return "R7";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic pexp(logic [2:0] k, logic [7:0] op, logic [7:0] d, logic w, logic [31:0] a);
    expq.push_back({k, op, d, w, a});
  endtask

  // flash command responder
  initial begin
    int lat;
    logic [51:0] snap, e, cur;
    lat = 0;
    cmd_done = 1'b0;
    cmd_rdata = 8'h00;
    forever begin
      @(negedge clk);
      cur = {cmd_kind, cmd_op, cmd_data, cmd_wide, cmd_addr};
      if (cmd_done) begin
        cmd_done = 1'b0;
        lat = 0;
      end else if (!rst_n || !cmd_valid) lat = 0;
      else begin
        lat++;
        if (lat == 1) snap = cur;
        else begin
          chk(snap == cur, "R11", "command changed while pending", longint'(cur), longint'(snap));
          if (!(cmd_kind == 3'd1 && allow_polls)) begin
            if (expq.size() == 0) chk(1'b0, ktag(cmd_kind), "unexpected command kind", cmd_kind, 7);
            else begin
              e = expq.pop_front();
              chk(e[51:49] == cmd_kind, ktag(e[51:49]), "command kind", cmd_kind, e[51:49]);
              if (e[51:49] == cmd_kind) begin
                if (cmd_kind <= 3'd2) chk(cmd_op == e[48:41], ktag(cmd_kind), "opcode", cmd_op, e[48:41]);
                if (cmd_kind == 3'd2 || cmd_kind == 3'd3)
                  chk(cmd_data == e[40:33], "R5", "data byte", cmd_data, e[40:33]);
                if (cmd_kind == 3'd2) begin
                  chk(cmd_addr == e[31:0], "R5", "program address", cmd_addr, e[31:0]);
                  chk(cmd_wide == e[32], "R4", "wide address flag", cmd_wide, e[32]);
                end
              end
            end
          end
          if (cmd_kind == 3'd4) busy_left = busy_n;
          if (cmd_kind == 3'd1) begin
            if (busy_left > 0) begin cmd_rdata = 8'h03; busy_left--; end
            else cmd_rdata = 8'hFE;
          end else cmd_rdata = 8'h00;
          cmd_done = 1'b1;
        end
      end
    end
  end

  // byte source
  initial begin
    bit acc, tog;
    acc = 0; tog = 0;
    din_valid = 1'b0;
    din_data = 8'h00;
    forever begin
      @(negedge clk);
      if (acc) void'(bq.pop_front());
      tog = ~tog;
      if (bq.size() > 0 && !(gap && tog)) begin
        din_valid = 1'b1;
        din_data = bq[0];
      end else din_valid = 1'b0;
      if (din_ready) chk(!cmd_valid, "R10", "byte ready while command pending", cmd_valid, 0);
      acc = din_valid && din_ready && rst_n;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic run(logic [31:0] addr, int len, int busy, bit g, bit to,
                     int exp_cnt, bit exp_rng, bit immediate, string tag);
    bit wide;
    logic [31:0] a;
    logic [7:0] d;
    logic [7:0] op;
    busy_n = busy;
    gap = g;
    wide = (longint'(addr) + len) > 64'h100_0000;
    op = wide ? 8'h12 : 8'h02;
    if (!exp_rng && len > 0) begin
      pexp(3'd0, 8'h06, 0, 0, 0);
      for (int i = 0; i < len; i++) begin
        a = addr + i;
        d = a[7:0] ^ 8'hA5;
        bq.push_back(d);
        if (i > 0 && a[7:0] == 8'h00) begin
          pexp(3'd4, 0, 0, 0, 0);
          for (int k = 0; k <= busy; k++) pexp(3'd1, 8'h05, 0, 0, 0);
          pexp(3'd0, 8'h06, 0, 0, 0);
          pexp(3'd2, op, d, wide, a);
        end else if (i == 0) pexp(3'd2, op, d, wide, a);
        else pexp(3'd3, 0, d, 0, 0);
      end
      pexp(3'd4, 0, 0, 0, 0);
      if (!to) for (int k = 0; k <= busy; k++) pexp(3'd1, 8'h05, 0, 0, 0);
    end
    allow_polls = to;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr = addr;
    req_len = 16'(len);
    @(negedge clk);
    req_valid = 1'b0;
    if (immediate) chk(done == 1'b1, tag, "done one cycle after request", done, 1);
    while (!done) @(negedge clk);
    chk(done_count == 16'(exp_cnt), tag, "done_count", done_count, exp_cnt);
    chk(err_range == exp_rng, tag, "err_range", err_range, exp_rng);
    chk(err_timeout == to, tag, "err_timeout", err_timeout, to);
    chk(expq.size() == 0, tag, "expected commands left over", expq.size(), 0);
    chk(bq.size() == 0, tag, "bytes left unconsumed", bq.size(), 0);
    allow_polls = 0;
    busy_left = 0;
    busy_n = 0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    req_len = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(din_ready == 1'b0, "R10", "din_ready after reset", din_ready, 0);
    chk(cmd_valid == 1'b0, "R11", "cmd_valid after reset", cmd_valid, 0);
    chk(done == 1'b0, "R8", "done after reset", done, 0);

    run(32'h0000_0040, 0, 0, 0, 0, 0, 0, 1, "R2");
    run(32'h01FF_FFFC, 8, 0, 0, 0, 0, 1, 1, "R1");
    run(32'h0000_0100, 5, 2, 0, 0, 5, 0, 0, "R8");
    run(32'h0000_01FC, 10, 1, 1, 0, 10, 0, 0, "R6");
    run(32'h0000_02F0, 16, 0, 0, 0, 16, 0, 0, "R8");
    run(32'h00FF_FFFE, 4, 1, 0, 0, 4, 0, 0, "R4");
    run(32'h00FF_FFF0, 16, 0, 1, 0, 16, 0, 0, "R4");
    run(32'h01FF_FFFC, 4, 0, 0, 0, 4, 0, 0, "R1");
    run(32'h0000_3000, 600, 3, 0, 0, 600, 0, 0, "R7");
    run(32'h0000_0500, 3, 100000, 0, 1, 3, 0, 0, "R9");
    run(32'h0000_0780, 2, 0, 0, 0, 2, 0, 0, "R3");

    summary();
    $finish;
  end

endmodule